// File: doc/BRIEF.md
# Interrupt pending and enable controller

This block collects interrupt events for a peripheral that has many sources and presents them to the host as one interrupt line. Each general event source sends a pulse one cycle wide. The pulse sets its own bit in a 32-bit pending register, and the bit stays set until the host clears it. Beside these, 64 per-channel loop flags are kept individually. The host sees them as one summary bit and the number of the highest channel that is pending. Because only one channel number is visible at a time, the host retires the flags one at a time by writing that channel number back.

A 32-bit enable register selects which pending sources may drive the interrupt line. One bit forces the line high no matter what is pending. The host reaches both registers through a simple port. A write strobe comes with a register select. The read data is combinational and follows the read select in the same cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending view and the enable register both read as zero, no loop flag is held, and `irq` is low.
- R2: A pulse on `evt_pulse[i]` (i = 0..7) sets pending bit 8+i on the next clock edge. The bit stays set until it is cleared by a write. Bits 31:16 and 7 of the pending view always read zero.
- R3: A pending write (`wr_sel`=0) clears each event bit 15:8 that is written as 1. Event bits written as 0 keep their value.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit remains set after that edge. The same holds for a loop flag that is set and cleared in the same cycle.
- R5: A pulse on `loop_hit[c]` sets loop flag c. Pending bit 6 reads 1 while any loop flag is held.
- R6: While bit 6 is 1, pending bits 5:0 give the highest channel number whose loop flag is held.
- R7: A pending write with bit 6 set clears only the loop flag whose number equals written bits 5:0. A pending write with bit 6 clear leaves every loop flag untouched.
- R8: When no loop flag is held, pending bits 6:0 read zero.
- R9: A write with `wr_sel`=1 stores all 32 bits into the enable register. Reading with `rd_sel`=1 returns it, and reading with `rd_sel`=0 returns the pending view, in the same cycle.
- R10: `irq` is high when an event bit 8+i is pending with enable bit i set, or when any loop flag is held with enable bit 8 set. Otherwise it is low, unless R11 applies.
- R11: While enable bit 31 is set, `irq` is high whatever is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 pending, 1 enable |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 1 | Read source: 0 pending view, 1 enable |
| rd_data | output | 32 | Combinational read data |
| evt_pulse | input | 8 | Single-cycle event pulses, one per source group |
| loop_hit | input | 64 | Single-cycle per-channel loop flag pulses |
| irq | output | 1 | Active-high interrupt request |

## Verification
Several properties are checked on every cycle. A latched event survives until a write with a 1 clears it. Clears of event bits take effect. The reported channel is always a held flag with no held flag above it. A cleared channel disappears while the other flags stay. The force bit always drives the line, and the line stays low when nothing enabled is pending. Only the bench's scenarios show the host-visible results: the exact read encodings, the clearing order of several channels down to an empty set, and the collision of an event with a clear. A reference model compares both read views and the interrupt line after every edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NCHAN = 64,
  parameter int NEVT  = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic [NEVT-1:0]  evt_pulse,
  input  logic [NCHAN-1:0] loop_hit,
  output logic             irq
);
  localparam int CHW       = $clog2(NCHAN);
  localparam int SUM_BIT   = CHW;
  localparam int EVT_LSB   = 8;
  localparam int LOOP_EN   = NEVT;
  localparam int FORCE_BIT = DW - 1;

  logic [NEVT-1:0]  evt_q;
  logic [NCHAN-1:0] loop_q;
  logic [DW-1:0]    en_q;
  logic [CHW-1:0]   top_idx;
  logic             loop_any;
  logic [NEVT-1:0]  evt_clr;
  logic [NCHAN-1:0] loop_clr;
  logic [DW-1:0]    pend_view;

  wire pend_wr = wr_en & ~wr_sel;
  wire en_wr   = wr_en & wr_sel;

  assign evt_clr = pend_wr ? wr_data[EVT_LSB +: NEVT] : '0;

  always_comb begin
    loop_clr = '0;
    if (pend_wr && wr_data[SUM_BIT])
      loop_clr[wr_data[CHW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      loop_q <= '0;
      en_q   <= '0;
    end else begin
      evt_q  <= (evt_q & ~evt_clr) | evt_pulse;
      loop_q <= (loop_q & ~loop_clr) | loop_hit;
      if (en_wr) en_q <= wr_data;
    end
  end

  always_comb begin
    top_idx = '0;
    for (int c = 0; c < NCHAN; c++)
      if (loop_q[c]) top_idx = CHW'(c);
  end

  assign loop_any = |loop_q;

  always_comb begin
    pend_view                    = '0;
    pend_view[EVT_LSB +: NEVT]   = evt_q;
    pend_view[SUM_BIT]           = loop_any;
    pend_view[CHW-1:0]           = top_idx;
  end

  assign rd_data = rd_sel ? en_q : pend_view;
  assign irq = (|(evt_q & en_q[NEVT-1:0])) | (loop_any & en_q[LOOP_EN]) | en_q[FORCE_BIT];
endmodule

module irq_aggregator_chk #(
  parameter int NCHAN = 64,
  parameter int NEVT  = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [DW-1:0]    wr_data,
  input logic [NEVT-1:0]  evt_pulse,
  input logic [NCHAN-1:0] loop_hit,
  input logic [NEVT-1:0]  evt_q,
  input logic [NCHAN-1:0] loop_q,
  input logic [DW-1:0]    en_q,
  input logic [$clog2(NCHAN)-1:0] top_idx,
  input logic             loop_any,
  input logic             irq
);
  localparam int CHW     = $clog2(NCHAN);
  localparam int EVT_LSB = 8;

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse))); // R4

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) || !(wr_en && !wr_sel) |=>
      (($past(evt_q) & ~evt_q &
        ~($past(wr_en && !wr_sel) ? $past(wr_data[EVT_LSB +: NEVT]) : '0)) == '0)); // R2

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && |(wr_data[EVT_LSB +: NEVT] & ~evt_pulse)) |=>
      ((evt_q & $past(wr_data[EVT_LSB +: NEVT] & ~evt_pulse)) == '0)); // R3

  AST_IDX_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q != '0) |-> (loop_q[top_idx] && (((loop_q >> top_idx) >> 1) == '0))); // R6

  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q == '0) |-> (top_idx == '0 && !loop_any)); // R8

  AST_LOOP_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[CHW] && loop_hit == '0) |=>
      (loop_q == ($past(loop_q) & ~(NCHAN'(1) << $past(wr_data[CHW-1:0]))))); // R7

  AST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[DW-1] |-> irq); // R11

  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[DW-1] && ((evt_q & en_q[NEVT-1:0]) == '0) && !((loop_q != '0) && en_q[NEVT])) |-> !irq); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(.NCHAN(NCHAN), .NEVT(NEVT), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .evt_pulse(evt_pulse), .loop_hit(loop_hit), .evt_q(evt_q), .loop_q(loop_q),
  .en_q(en_q), .top_idx(top_idx), .loop_any(loop_any), .irq(irq)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  evt_pulse = '0;
  logic [63:0] loop_hit = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  m_evt = '0;
  logic [63:0] m_loop = '0;
  logic [31:0] m_en = '0;

  always #10 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_pulse(evt_pulse), .loop_hit(loop_hit), .irq(irq)
  );

  function automatic logic [31:0] exp_pend();
    logic [31:0] r;
    bit found;
    r = '0;
    r[15:8] = m_evt;
    found = 0;
    for (int c = 63; c >= 0; c--) begin
      if (!found && m_loop[c]) begin
        found = 1;
        r[6] = 1'b1;
        r[5:0] = 6'(c);
      end
    end
    return r;
  endfunction

  function automatic logic exp_irq();
    return (|(m_evt & m_en[7:0])) || (m_loop != 0 && m_en[8]) || m_en[31];
  endfunction

  task automatic check(input string tag);
    logic [31:0] e;
    e = exp_pend();
    rd_sel = 1'b0; #1;
    total++;
    if (rd_data !== e) begin bad++; $display("FAIL %s pending act=%h exp=%h", tag, rd_data, e); end
    rd_sel = 1'b1; #1;
    total++;
    if (rd_data !== m_en) begin bad++; $display("FAIL %s enable act=%h exp=%h", tag, rd_data, m_en); end
    total++;
    if (irq !== exp_irq()) begin bad++; $display("FAIL %s irq act=%b exp=%b", tag, irq, exp_irq()); end
    rd_sel = 1'b0;
  endtask

  task automatic cyc(input bit we, input bit sel, input logic [31:0] d,
                     input logic [7:0] ev, input logic [63:0] lh, input string tag);
    wr_en = we; wr_sel = sel; wr_data = d; evt_pulse = ev; loop_hit = lh;
    @(posedge clk);
    if (we && !sel) begin
      m_evt = m_evt & ~d[15:8];
      if (d[6]) m_loop[d[5:0]] = 1'b0;
    end
    if (we && sel) m_en = d;
    m_evt = m_evt | ev;
    m_loop = m_loop | lh;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = '0; evt_pulse = '0; loop_hit = '0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    for (int i = 0; i < 8; i++) cyc(0, 0, '0, 8'(1 << i), '0, "R2");
    idle("R2");
    cyc(1, 0, 32'hFFFF_00BF & 32'hFFFF_00BF & ~32'h0000_FF40, '0, '0, "R3");
    cyc(1, 0, 32'h0000_5500, '0, '0, "R3");
    cyc(1, 0, 32'h0000_0000, '0, '0, "R3");
    cyc(1, 0, 32'h0000_AA00, 8'h02, '0, "R4");
    cyc(1, 0, 32'h0000_0200, '0, '0, "R3");

    cyc(0, 0, '0, '0, 64'h0000_0000_0000_0008, "R5");
    cyc(0, 0, '0, '0, 64'h8000_0000_0002_0000, "R6");
    cyc(1, 0, 32'h0000_007F, '0, '0, "R6");
    cyc(1, 0, 32'h0000_0011, '0, '0, "R7");
    cyc(1, 0, 32'h0000_0043, '0, '0, "R7");
    cyc(1, 0, 32'h0000_0045, '0, '0, "R7");
    cyc(1, 0, 32'h0000_0051, 8'h00, 64'h0000_0000_0002_0000, "R4");
    cyc(1, 0, 32'h0000_0051, '0, '0, "R8");
    cyc(0, 0, '0, '0, 64'h0000_0000_0000_0001, "R6");
    cyc(1, 0, 32'h0000_0040, '0, '0, "R8");

    cyc(1, 1, 32'h1234_5601, '0, '0, "R9");
    cyc(0, 0, '0, 8'h01, '0, "R10");
    cyc(1, 0, 32'h0000_0100, '0, '0, "R10");
    cyc(1, 1, 32'h0000_0100, 8'h80, '0, "R10");
    cyc(0, 0, '0, '0, 64'h0000_0400_0000_0000, "R10");
    cyc(1, 0, 32'h0000_006A, '0, '0, "R10");
    cyc(1, 1, 32'h8000_0000, '0, '0, "R11");
    cyc(1, 0, 32'h0000_FF00, '0, '0, "R11");
    cyc(1, 1, 32'h0000_0000, '0, '0, "R10");

    begin
      logic [31:0] lf = 32'hACE1_2345;
      for (int k = 0; k < 400; k++) begin
        logic [63:0] lh;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lh = (lf[3:0] == 0) ? (64'd1 << lf[9:4]) : 64'd0;
        cyc(lf[12], lf[13] & lf[14], {lf[31], 15'd0, lf[27:20], 1'b0, lf[15], lf[5:0]},
            (lf[19:17] == 0) ? 8'(1 << lf[30:28]) : 8'h00, lh, "R3 R6 R10");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule